// File: doc/BRIEF.md
# Pause Frame Transmit Scheduler

This block sits beside an Ethernet MAC transmitter and decides when a flow-control PAUSE frame must go out, and which quanta value it carries. Buffer logic raises a level request while it wants the link partner to stop sending. The block then asks the frame builder for one PAUSE frame carrying the programmed quanta. It waits for a done handshake, and then runs a countdown of the quanta it announced. It does not wait for that countdown to expire. When the count falls to a programmable refresh threshold and the request is still high, it sends a fresh frame with the full quanta. Typical programming is 0xFFFF for the quanta and 0xFF00 for the threshold. When the request drops, a single frame with quanta zero lets the partner resume.

On the receive side, decoded PAUSE quanta from the link partner load a hold timer. While that timer is nonzero, the block holds off new transmit frames. A received quanta of zero lifts the hold at once. An ignore control makes received PAUSE frames have no effect. Transmit generation and receive honoring are enabled separately. All countdowns advance once per pause quantum, which is QUANTUM_BITS bit times, and a tick input marks each bit time.

Top module: `pause_sched`

## Requirements
- R1: After reset, frame_req_o and tx_hold_o are 0.
- R2: While tx_pause_en_i and pause_req_i are 1 and no pause is active, the block raises frame_req_o with frame_quanta_o equal to quanta_i. A done pulse (frame_done_i=1 while frame_req_o=1) drops frame_req_o on the next cycle.
- R3: At most one frame request is outstanding. frame_req_o and frame_quanta_o stay unchanged until done, and any new trigger waits.
- R4: Every countdown decrements once per QUANTUM_BITS cycles in which tick_i=1 and stops at zero.
- R5: After a frame with nonzero quanta completes, the transmit countdown loads that quanta. While the request stays high, a new frame carrying the full quanta_i is raised once the countdown is at or below thresh_i.
- R6: When the effective request (pause_req_i and tx_pause_en_i) drops while a pause is active, exactly one frame with quanta 0 is sent, and then no frame follows.
- R7: With tx_pause_en_i=0, no frame with nonzero quanta is started.
- R8: A received PAUSE (rx_pause_vld_i=1) with nonzero rx_quanta_i and rx_pause_ign_i=0 raises tx_hold_o on the next cycle. The hold lasts until the loaded count reaches zero.
- R9: A received PAUSE with quanta 0 and rx_pause_ign_i=0 clears tx_hold_o on the next cycle.
- R10: While rx_pause_ign_i=1, received PAUSE frames do not load the hold, and tx_hold_o is 0.
- R11: frame_done_i has no effect while frame_req_o is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One bit time elapsed |
| tx_pause_en_i | input | 1 | Enable PAUSE generation |
| rx_pause_ign_i | input | 1 | Ignore received PAUSE frames |
| pause_req_i | input | 1 | Level request from buffer logic |
| quanta_i | input | QW | Quanta to announce |
| thresh_i | input | QW | Refresh threshold |
| frame_req_o | output | 1 | Request to send a PAUSE frame |
| frame_quanta_o | output | QW | Quanta field for the requested frame |
| frame_done_i | input | 1 | Frame sent |
| rx_pause_vld_i | input | 1 | Decoded PAUSE received |
| rx_quanta_i | input | QW | Received quanta |
| tx_hold_o | output | 1 | Hold off new transmit frames |

## Verification
A wrong transmit countdown or a lost active flag shows up at frame_req_o. The cost is a missed or early refresh, or a missing or extra zero-quanta release, and it appears within one quantum of the threshold crossing or at the first request edge. A corrupt hold count shows on tx_hold_o, as a hold that ends early or lingers, and is visible on the cycle after a received frame. A prescaler phase error shifts both of these by up to a quantum. The bench compares every output each cycle against a behavioural model, so each such divergence is reported on the cycle it first appears.

// File: rtl/pause_pkg.sv
package pause_pkg;
  typedef enum logic [0:0] {
    TX_IDLE = 1'b0,
    TX_BUSY = 1'b1
  } tx_state_e;
endpackage

// File: rtl/pause_prescaler.sv
module pause_prescaler #(
  parameter int unsigned QUANTUM_BITS = 512
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  output logic quantum_o
);
  localparam int unsigned CW = (QUANTUM_BITS > 2) ? $clog2(QUANTUM_BITS) : 1;
  localparam logic [CW-1:0] LAST = CW'(QUANTUM_BITS - 1);

  logic [CW-1:0] cnt_q;

  assign quantum_o = tick_i && (cnt_q == LAST);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
    end else if (tick_i) begin
      if (cnt_q == LAST) cnt_q <= '0;
      else               cnt_q <= cnt_q + 1'b1;
    end
  end
endmodule

// File: rtl/pause_tx_ctrl.sv
module pause_tx_ctrl
  import pause_pkg::*;
#(
  parameter int unsigned QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          quantum_i,
  input  logic          req_i,
  input  logic [QW-1:0] quanta_i,
  input  logic [QW-1:0] thresh_i,
  input  logic          done_i,
  output logic          frame_req_o,
  output logic [QW-1:0] frame_quanta_o
);
  tx_state_e     state_q;
  logic          act_q;
  logic [QW-1:0] tmr_q;
  logic [QW-1:0] fq_q;
  logic          start_on, refresh, release_p, tmr_dec;

  assign start_on  = req_i && !act_q;
  assign refresh   = req_i && act_q && (tmr_q <= thresh_i);
  assign release_p = !req_i && act_q;
  assign tmr_dec   = quantum_i && (tmr_q != '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= TX_IDLE;
      act_q   <= 1'b0;
      tmr_q   <= '0;
      fq_q    <= '0;
    end else if (state_q == TX_BUSY) begin
      if (done_i) begin
        state_q <= TX_IDLE;
        act_q   <= (fq_q != '0);
        tmr_q   <= fq_q;
      end else if (tmr_dec) begin
        tmr_q <= tmr_q - 1'b1;
      end
    end else begin
      if (tmr_dec) tmr_q <= tmr_q - 1'b1;
      if (start_on || refresh) begin
        state_q <= TX_BUSY;
        fq_q    <= quanta_i;
      end else if (release_p) begin
        state_q <= TX_BUSY;
        fq_q    <= '0;
      end
    end
  end

  assign frame_req_o    = (state_q == TX_BUSY);
  assign frame_quanta_o = fq_q;
endmodule

// File: rtl/pause_rx_hold.sv
module pause_rx_hold #(
  parameter int unsigned QW = 16
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          quantum_i,
  input  logic          ign_i,
  input  logic          vld_i,
  input  logic [QW-1:0] quanta_i,
  output logic          hold_o
);
  logic [QW-1:0] hold_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      hold_q <= '0;
    end else if (vld_i && !ign_i) begin
      hold_q <= quanta_i;
    end else if (quantum_i && (hold_q != '0)) begin
      hold_q <= hold_q - 1'b1;
    end
  end

  assign hold_o = (hold_q != '0) && !ign_i;
endmodule

// File: rtl/pause_sched.sv
module pause_sched #(
  parameter int unsigned QW           = 16,
  parameter int unsigned QUANTUM_BITS = 512
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          tick_i,
  input  logic          tx_pause_en_i,
  input  logic          rx_pause_ign_i,
  input  logic          pause_req_i,
  input  logic [QW-1:0] quanta_i,
  input  logic [QW-1:0] thresh_i,
  output logic          frame_req_o,
  output logic [QW-1:0] frame_quanta_o,
  input  logic          frame_done_i,
  input  logic          rx_pause_vld_i,
  input  logic [QW-1:0] rx_quanta_i,
  output logic          tx_hold_o
);
  logic quantum;
  logic eff_req;

  assign eff_req = pause_req_i && tx_pause_en_i;

  pause_prescaler #(.QUANTUM_BITS(QUANTUM_BITS)) u_presc (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .quantum_o (quantum)
  );

  pause_tx_ctrl #(.QW(QW)) u_tx (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .quantum_i      (quantum),
    .req_i          (eff_req),
    .quanta_i       (quanta_i),
    .thresh_i       (thresh_i),
    .done_i         (frame_done_i),
    .frame_req_o    (frame_req_o),
    .frame_quanta_o (frame_quanta_o)
  );

  pause_rx_hold #(.QW(QW)) u_rx (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .quantum_i (quantum),
    .ign_i     (rx_pause_ign_i),
    .vld_i     (rx_pause_vld_i),
    .quanta_i  (rx_quanta_i),
    .hold_o    (tx_hold_o)
  );
endmodule

// File: rtl/pause_sched_chk.sv
module pause_sched_chk #(
  parameter int unsigned QW = 16
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic          tx_pause_en_i,
  input logic          rx_pause_ign_i,
  input logic          frame_req_o,
  input logic [QW-1:0] frame_quanta_o,
  input logic          frame_done_i,
  input logic          rx_pause_vld_i,
  input logic [QW-1:0] rx_quanta_i,
  input logic          tx_hold_o
);
  a_r3_req_held: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_req_o && !frame_done_i |=> frame_req_o && $stable(frame_quanta_o));

  a_r2_done_drops: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_req_o && frame_done_i |=> !frame_req_o);

  a_r7_no_start: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !tx_pause_en_i && !frame_req_o |=> !frame_req_o || (frame_quanta_o == '0));

  a_r8_hold_load: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_vld_i && !rx_pause_ign_i && (rx_quanta_i != '0) |=> tx_hold_o || rx_pause_ign_i);

  a_r9_zero_clear: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_vld_i && !rx_pause_ign_i && (rx_quanta_i == '0) |=> !tx_hold_o);

  a_r10_ignored: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rx_pause_ign_i |-> !tx_hold_o);
endmodule

bind pause_sched pause_sched_chk #(.QW(QW)) u_chk (
  .clk_i          (clk_i),
  .rst_ni         (rst_ni),
  .tx_pause_en_i  (tx_pause_en_i),
  .rx_pause_ign_i (rx_pause_ign_i),
  .frame_req_o    (frame_req_o),
  .frame_quanta_o (frame_quanta_o),
  .frame_done_i   (frame_done_i),
  .rx_pause_vld_i (rx_pause_vld_i),
  .rx_quanta_i    (rx_quanta_i),
  .tx_hold_o      (tx_hold_o)
);

// File: tb/sim_pause_sched.sv
`timescale 1ns/1ps
module sim_pause_sched;
  localparam int QW = 16;
  localparam int QB = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tick = 1'b0, txen = 1'b0, ign = 1'b0, preq = 1'b0, done = 1'b0, vld = 1'b0;
  logic [QW-1:0] quanta = '0, thresh = '0, rxq = '0;
  logic frame_req, hold;
  logic [QW-1:0] frame_q;

  always #2.5 clk = ~clk;

  pause_sched #(.QW(QW), .QUANTUM_BITS(QB)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .tx_pause_en_i(txen),
    .rx_pause_ign_i(ign), .pause_req_i(preq), .quanta_i(quanta), .thresh_i(thresh),
    .frame_req_o(frame_req), .frame_quanta_o(frame_q), .frame_done_i(done),
    .rx_pause_vld_i(vld), .rx_quanta_i(rxq), .tx_hold_o(hold)
  );

  int total = 0, bad = 0, cyc = 0;
  int m_pcnt, m_req, m_q, m_act, m_tmr, m_hold;
  bit auto_done = 1'b0;
  int wcnt = 0;
  int n_frames = 0, n_zero = 0, n_wrong = 0;

  // reference model
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pcnt = 0; m_req = 0; m_q = 0; m_act = 0; m_tmr = 0; m_hold = 0;
    end else begin
      bit pulse, eff;
      int old_t;
      pulse = tick && (m_pcnt == QB - 1);
      if (tick) m_pcnt = (m_pcnt + 1) % QB;
      eff = preq && txen;
      old_t = m_tmr;
      if (m_req != 0) begin
        if (done) begin
          m_req = 0; m_tmr = m_q; m_act = (m_q != 0);
        end else if (pulse && m_tmr > 0) m_tmr = m_tmr - 1;
      end else begin
        if (pulse && m_tmr > 0) m_tmr = m_tmr - 1;
        if (eff && (m_act == 0 || old_t <= int'(thresh))) begin
          m_req = 1; m_q = int'(quanta);
        end else if (!eff && m_act != 0) begin
          m_req = 1; m_q = 0;
        end
      end
      if (vld && !ign) m_hold = int'(rxq);
      else if (pulse && m_hold > 0) m_hold = m_hold - 1;
    end
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      bad++; total++;
      $display("FAIL R1 watchdog actual=running expected=finished");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  task automatic step();
    @(negedge clk);
    if (rst_n) begin
      check(frame_req == (m_req != 0), "R3 frame_req_o", int'(frame_req), m_req);
      if (m_req != 0) check(int'(frame_q) == m_q, "R5 frame_quanta_o", int'(frame_q), m_q);
      check(hold == ((m_hold != 0) && !ign), "R8 tx_hold_o", int'(hold),
            int'((m_hold != 0) && !ign));
    end
    if (auto_done) begin
      if (frame_req && !done) begin
        wcnt++;
        if (wcnt >= 2) begin
          done = 1'b1; wcnt = 0; n_frames++;
          if (frame_q == '0) n_zero++;
          else if (frame_q != quanta) n_wrong++;
        end
      end else begin
        done = 1'b0;
      end
    end
  endtask

  task automatic run(input int n);
    for (int i = 0; i < n; i++) step();
  endtask

  task automatic clr_counts();
    n_frames = 0; n_zero = 0; n_wrong = 0;
  endtask

  initial begin
    int hc;
    run(3);
    check(frame_req == 1'b0, "R1 frame_req_o in reset", int'(frame_req), 0);
    check(hold == 1'b0, "R1 tx_hold_o in reset", int'(hold), 0);
    rst_n = 1'b1;
    step();
    check(frame_req == 1'b0, "R1 frame_req_o after reset", int'(frame_req), 0);

    // R2/R5: request held, refresh at threshold
    tick = 1'b1; txen = 1'b1; quanta = 16'd20; thresh = 16'd16; auto_done = 1'b1;
    clr_counts();
    preq = 1'b1;
    step();
    check(frame_req == 1'b1, "R2 request raised", int'(frame_req), 1);
    check(frame_q == 16'd20, "R2 quanta carried", int'(frame_q), 20);
    run(200);
    check(n_frames >= 5, "R5 refresh frames", n_frames, 5);
    check(n_zero == 0 && n_wrong == 0, "R5 full quanta on refresh", n_zero + n_wrong, 0);

    // R6: release
    clr_counts();
    preq = 1'b0;
    run(60);
    check(n_frames == 1, "R6 single release frame", n_frames, 1);
    check(n_zero == 1, "R6 release quanta zero", n_zero, 1);

    // R7: tx disabled
    clr_counts();
    txen = 1'b0; preq = 1'b1;
    run(60);
    check(n_frames == 0, "R7 no frame when disabled", n_frames, 0);
    check(frame_req == 1'b0, "R7 frame_req_o low", int'(frame_req), 0);

    // R11: stray done
    auto_done = 1'b0;
    done = 1'b1; step(); done = 1'b0; step();
    check(frame_req == 1'b0, "R11 stray done ignored", int'(frame_req), 0);

    // R3: single outstanding without done
    txen = 1'b1; thresh = 16'd100; quanta = 16'd7;
    run(2);
    quanta = 16'd9;
    run(30);
    check(frame_req == 1'b1, "R3 request held", int'(frame_req), 1);
    check(frame_q == 16'd7, "R3 quanta stable", int'(frame_q), 7);
    done = 1'b1; step(); done = 1'b0;
    check(frame_req == 1'b0, "R2 drop after done", int'(frame_req), 0);
    step();
    check(frame_req == 1'b1 && frame_q == 16'd9, "R5 refresh above thresh", int'(frame_q), 9);
    preq = 1'b0; auto_done = 1'b1;
    run(20);
    auto_done = 1'b0; done = 1'b0;

    // R8/R4: hold duration
    rxq = 16'd5; vld = 1'b1; step(); vld = 1'b0;
    check(hold == 1'b1, "R8 hold raised", int'(hold), 1);
    hc = 1;
    for (int i = 0; i < 40; i++) begin step(); if (hold) hc++; end
    check(hc >= 17 && hc <= 20, "R4 hold length in quanta", hc, 18);

    // R9: zero clears
    rxq = 16'd100; vld = 1'b1; step(); vld = 1'b0;
    run(5);
    check(hold == 1'b1, "R8 long hold", int'(hold), 1);
    rxq = 16'd0; vld = 1'b1; step(); vld = 1'b0;
    check(hold == 1'b0, "R9 zero clears hold", int'(hold), 0);

    // R10: ignore
    ign = 1'b1; rxq = 16'd50; vld = 1'b1; step(); vld = 1'b0;
    check(hold == 1'b0, "R10 ignored frame", int'(hold), 0);
    ign = 1'b0; step();
    check(hold == 1'b0, "R10 ignored frame not loaded", int'(hold), 0);
    rxq = 16'd50; vld = 1'b1; step(); vld = 1'b0;
    ign = 1'b1; step();
    check(hold == 1'b0, "R10 hold masked", int'(hold), 0);
    ign = 1'b0; step();
    check(hold == 1'b1, "R10 hold resumes", int'(hold), 1);

    // R4: sparse ticks with traffic
    auto_done = 1'b1; quanta = 16'd6; thresh = 16'd3; preq = 1'b1;
    for (int i = 0; i < 300; i++) begin
      step();
      tick = (i % 3) == 0;
      if (i == 150) preq = 1'b0;
      if (i == 40) begin rxq = 16'd4; vld = 1'b1; end else vld = 1'b0;
    end
    run(20);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule